// File: doc/BRIEF.md
# Faulty Block Pairing Engine

This block runs once at start-up, after a memory self-test has measured which cells of each cache block are unreliable at the current operating point. Software or a test controller first loads, for every block, a defect flag and a fault mask that has one bit per cell position. It then pulses a start input. The engine walks the cache one block per cycle. For each block it writes one entry into a grouping table: the block is kept standalone, paired with another faulty block of the same set, or switched off. When a pair is formed, it also writes one entry into a selector table. That entry tells the read path which copy of each bit to trust.

Two faulty blocks can be joined into one working block only when no cell position is bad in both of them. The search is greedy and restricted to one set. Ways are taken in ascending order. Each faulty way that is still free takes the lowest-numbered later way that is faulty, free and compatible with it. The earlier way of a pair is the primary and the later way is the secondary. Every selector entry belongs to a primary and carries a 1 wherever the primary's own cell is bad. At those positions the secondary's bit must be used.

Top module: `fault_pair_engine`

## Requirements
- R1: While `busy` is low, a load pulse (`ld_en`) stores `ld_bad` and `ld_mask` for block (`ld_set`, `ld_way`). A load pulse while `busy` is high is ignored and does not change any later table entry.
- R2: A `start` pulse while idle begins a scan. The engine makes exactly one grouping-table write per block, one per cycle, in set-major order with ways ascending inside a set. A `start` pulse during a scan is ignored.
- R3: A block whose defect flag is clear gets kind SOLO (2'b00) with the partner field equal to its own way, whatever its mask holds. It gets no selector write.
- R4: Two faulty blocks are compatible only when the bitwise AND of their fault masks is zero.
- R5: A faulty, still-free way pairs with the lowest-numbered later way of the same set that is faulty, free and compatible with it. The earlier way is written as kind PRIMARY (2'b01), and its partner field holds the chosen way.
- R6: The later way of a pair is written as kind SECONDARY (2'b10), and its partner field holds the primary's way.
- R7: Each pair produces exactly one selector write, in the same cycle as the primary's grouping write and at the primary's set and way. Its mask equals the primary's fault mask, so bit i = 1 means the secondary's bit i is used.
- R8: A faulty way that is neither already taken nor able to find a partner is written as kind DISABLED (2'b11), with the partner field equal to its own way.
- R9: Pairing never crosses sets. Faulty blocks in different sets stay unpaired even when they are compatible.
- R10: `busy` is high from the cycle after an accepted start until the scan ends. `done` is a one-cycle pulse in the cycle after the last grouping write. During that pulse `busy` is low and no write is presented. After reset `busy`, `done`, `gt_we` and `sel_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load pulse for one block's fault data |
| ld_set | input | SET_W | Set index of the block being loaded |
| ld_way | input | WAY_W | Way index of the block being loaded |
| ld_bad | input | 1 | Defect flag of the block being loaded |
| ld_mask | input | BLK_BITS | Per-cell fault mask, 1 = bad cell |
| start | input | 1 | Begin a pairing scan |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse after the last table write |
| gt_we | output | 1 | Grouping-table write strobe |
| gt_set | output | SET_W | Grouping-table write set |
| gt_way | output | WAY_W | Grouping-table write way |
| gt_kind | output | 2 | 00 solo, 01 primary, 10 secondary, 11 disabled |
| gt_partner | output | WAY_W | Partner way (own way for solo or disabled) |
| sel_we | output | 1 | Selector-table write strobe |
| sel_set | output | SET_W | Selector write set (primary's set) |
| sel_way | output | WAY_W | Selector write way (primary's way) |
| sel_mask | output | BLK_BITS | 1 = take the secondary's bit at this position |

## Verification
The bench first targets two faulty ways that share one bad cell. A design that tested compatibility with OR, or skipped the test, would pair them and produce a selector mask that points at a bad bit on both sides. A greedy test gives one way several compatible partners. Pairing with anything other than the nearest free one, or letting an already-claimed way be claimed a second time, shows up as wrong partner fields. Further scenarios cover these cases:
- a lone faulty block at the end of a set next to a compatible block at the start of the following set, which would catch a search that runs past the set boundary;
- a flag-clear block with a dirty mask;
- loads and starts issued during a scan, which catch a store that is not locked or an engine that restarts;
- the exact cycle of the done pulse relative to the final write.

// File: rtl/fpair_pkg.sv
// Shared types of the faulty block pairing engine.
package fpair_pkg;

    // Grouping-table entry kind; the read path decodes these values.
    typedef enum logic [1:0] {
        KIND_SOLO = 2'b00,
        KIND_PRIM = 2'b01,
        KIND_SEC  = 2'b10,
        KIND_OFF  = 2'b11
    } pair_kind_e;

    // Scan sequencer states.
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'b00,
        SQ_SCAN  = 2'b01,
        SQ_FLUSH = 2'b10
    } seq_state_e;

endpackage

// File: rtl/fault_store.sv
// Holds the defect flag and fault mask of every block.
// Assumes: ld indices are in range; NUM_WAYS is a power of two.
// Writes are blocked while lock is high; one whole set is read combinationally.
module fault_store #(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 4,
    parameter int BLK_BITS = 16,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int BLKS  = NUM_SETS * NUM_WAYS,
    localparam int IDX_W = $clog2(BLKS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         lock,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic                         wr_bad,
    input  logic [BLK_BITS-1:0]          wr_mask,
    input  logic [SET_W-1:0]             rd_set,
    output logic [NUM_WAYS*BLK_BITS-1:0] rd_masks,
    output logic [NUM_WAYS-1:0]          rd_bad
);

    logic [BLK_BITS-1:0] mask_mem [BLKS];
    logic [BLKS-1:0]     bad_vec;
    logic [IDX_W-1:0]    wr_idx;
    logic [IDX_W-1:0]    rd_base;

    assign wr_idx  = IDX_W'(wr_set) * IDX_W'(NUM_WAYS) + IDX_W'(wr_way);
    assign rd_base = IDX_W'(rd_set) * IDX_W'(NUM_WAYS);

    // Store one block's fault data when loading is allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_vec <= '0;
            for (int i = 0; i < BLKS; i++) mask_mem[i] <= '0;
        end else if (wr_en && !lock) begin
            bad_vec[wr_idx]  <= wr_bad;
            mask_mem[wr_idx] <= wr_mask;
        end
    end

    // Present every way of the addressed set.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
        assign rd_masks[w*BLK_BITS +: BLK_BITS] = mask_mem[rd_base + IDX_W'(w)];
        assign rd_bad[w]                        = bad_vec[rd_base + IDX_W'(w)];
    end

    // A load attempted during a scan leaves the flags untouched.
    assert_locked_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock) |=> $stable(bad_vec));

endmodule

// File: rtl/pair_finder.sv
// Finds the partner of the current way inside one set.
// Candidates are later ways that are faulty, not yet claimed, and whose
// fault mask shares no bad cell with the current way; the lowest one wins.
module pair_finder #(
    parameter int NUM_WAYS = 4,
    parameter int BLK_BITS = 16,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS*BLK_BITS-1:0] set_masks,
    input  logic [NUM_WAYS-1:0]          set_bad,
    input  logic [NUM_WAYS-1:0]          free_ways,
    input  logic [WAY_W-1:0]             cur_way,
    output logic                         found,
    output logic [WAY_W-1:0]             match_way,
    output logic [BLK_BITS-1:0]          cur_mask
);

    logic [BLK_BITS-1:0] way_mask [NUM_WAYS];
    logic [NUM_WAYS-1:0] cand;

    // Unpack masks and flag every eligible candidate.
    for (genvar j = 0; j < NUM_WAYS; j++) begin : g_cand
        assign way_mask[j] = set_masks[j*BLK_BITS +: BLK_BITS];
        assign cand[j] = set_bad[j] && free_ways[j] && (WAY_W'(j) > cur_way)
                         && ((way_mask[j] & cur_mask) == '0);
    end

    assign cur_mask = way_mask[cur_way];

    // Pick the lowest-numbered candidate.
    always_comb begin
        found     = 1'b0;
        match_way = '0;
        for (int j = NUM_WAYS - 1; j >= 0; j--) begin
            if (cand[j]) begin
                found     = 1'b1;
                match_way = WAY_W'(j);
            end
        end
    end

    // A partner always lies after the current way in the walk.
    always_comb begin
        if (found) begin
            assert_forward_pick_R5: assert (match_way > cur_way);
        end
    end

endmodule

// File: rtl/pair_sequencer.sv
// Walks every block once and issues the table writes.
// Assumes: fault data of the addressed set is valid in the same cycle;
// the finder result belongs to the current way.
// Writes are registered, so a block processed in cycle t is written in t+1.
module pair_sequencer #(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 4,
    parameter int BLK_BITS = 16,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1),
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [NUM_WAYS-1:0]          set_bad,
    input  logic                         found,
    input  logic [WAY_W-1:0]             match_way,
    input  logic [BLK_BITS-1:0]          cur_mask,
    output logic [SET_W-1:0]             rd_set,
    output logic [WAY_W-1:0]             cur_way,
    output logic [NUM_WAYS-1:0]          free_ways,
    output logic                         busy,
    output logic                         done,
    output logic                         gt_we,
    output logic [SET_W-1:0]             gt_set,
    output logic [WAY_W-1:0]             gt_way,
    output fpair_pkg::pair_kind_e        gt_kind,
    output logic [WAY_W-1:0]             gt_partner,
    output logic                         sel_we,
    output logic [SET_W-1:0]             sel_set,
    output logic [WAY_W-1:0]             sel_way,
    output logic [BLK_BITS-1:0]          sel_mask
);
    import fpair_pkg::*;

    seq_state_e          state;
    logic [SET_W-1:0]    set_q;
    logic [WAY_W-1:0]    way_q;
    logic [NUM_WAYS-1:0] taken;
    logic [WAY_W-1:0]    part_q [NUM_WAYS];
    logic                cur_bad;

    assign rd_set    = set_q;
    assign cur_way   = way_q;
    assign free_ways = ~taken;
    assign busy      = (state != SQ_IDLE);
    assign cur_bad   = set_bad[way_q];

    // Scan state machine, claim tracking and registered table writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            set_q      <= '0;
            way_q      <= '0;
            taken      <= '0;
            done       <= 1'b0;
            gt_we      <= 1'b0;
            gt_set     <= '0;
            gt_way     <= '0;
            gt_kind    <= KIND_SOLO;
            gt_partner <= '0;
            sel_we     <= 1'b0;
            sel_set    <= '0;
            sel_way    <= '0;
            sel_mask   <= '0;
            for (int i = 0; i < NUM_WAYS; i++) part_q[i] <= '0;
        end else begin
            gt_we  <= 1'b0;
            sel_we <= 1'b0;
            done   <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state <= SQ_SCAN;
                        set_q <= '0;
                        way_q <= '0;
                        taken <= '0;
                    end
                end
                SQ_SCAN: begin
                    gt_we  <= 1'b1;
                    gt_set <= set_q;
                    gt_way <= way_q;
                    if (!cur_bad) begin
                        gt_kind    <= KIND_SOLO;
                        gt_partner <= way_q;
                    end else if (taken[way_q]) begin
                        gt_kind    <= KIND_SEC;
                        gt_partner <= part_q[way_q];
                    end else if (found) begin
                        gt_kind           <= KIND_PRIM;
                        gt_partner        <= match_way;
                        taken[match_way]  <= 1'b1;
                        part_q[match_way] <= way_q;
                        sel_we            <= 1'b1;
                        sel_set           <= set_q;
                        sel_way           <= way_q;
                        sel_mask          <= cur_mask;
                    end else begin
                        gt_kind    <= KIND_OFF;
                        gt_partner <= way_q;
                    end
                    if (way_q == LAST_WAY) begin
                        way_q <= '0;
                        taken <= '0;
                        if (set_q == LAST_SET) state <= SQ_FLUSH;
                        else                   set_q <= set_q + 1'b1;
                    end else begin
                        way_q <= way_q + 1'b1;
                    end
                end
                SQ_FLUSH: begin
                    state <= SQ_IDLE;
                    done  <= 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Selector writes only accompany a primary entry at the same slot.
    assert_sel_at_primary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |-> (gt_we && gt_kind == KIND_PRIM && sel_way == gt_way && sel_set == gt_set));

    // Pair members never point at themselves.
    assert_partner_other_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gt_we && (gt_kind == KIND_PRIM || gt_kind == KIND_SEC)) |-> (gt_partner != gt_way));

    // Standalone and disabled entries point at their own way.
    assert_self_pointer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gt_we && (gt_kind == KIND_SOLO || gt_kind == KIND_OFF)) |-> (gt_partner == gt_way));

    // Back-to-back writes advance by one block, set-major.
    assert_walk_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gt_we && $past(gt_we)) |->
        ((gt_set == $past(gt_set) && gt_way == WAY_W'($past(gt_way) + 1'b1)) ||
         (gt_way == '0 && $past(gt_way) == LAST_WAY && gt_set == SET_W'($past(gt_set) + 1'b1))));

    // Done follows the final write and carries no write itself.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(gt_we) && !gt_we && !busy));

endmodule

// File: rtl/fault_pair_engine.sv
// Top of the start-up pairing engine: fault store, partner finder and
// scan sequencer. Assumes loads happen before start and NUM_WAYS >= 2.
module fault_pair_engine #(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 4,
    parameter int BLK_BITS = 16,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_en,
    input  logic [SET_W-1:0]    ld_set,
    input  logic [WAY_W-1:0]    ld_way,
    input  logic                ld_bad,
    input  logic [BLK_BITS-1:0] ld_mask,
    input  logic                start,
    output logic                busy,
    output logic                done,
    output logic                gt_we,
    output logic [SET_W-1:0]    gt_set,
    output logic [WAY_W-1:0]    gt_way,
    output logic [1:0]          gt_kind,
    output logic [WAY_W-1:0]    gt_partner,
    output logic                sel_we,
    output logic [SET_W-1:0]    sel_set,
    output logic [WAY_W-1:0]    sel_way,
    output logic [BLK_BITS-1:0] sel_mask
);

    logic [NUM_WAYS*BLK_BITS-1:0] set_masks;
    logic [NUM_WAYS-1:0]          set_bad;
    logic [NUM_WAYS-1:0]          free_ways;
    logic [SET_W-1:0]             rd_set;
    logic [WAY_W-1:0]             cur_way;
    logic [WAY_W-1:0]             match_way;
    logic [BLK_BITS-1:0]          cur_mask;
    logic                         found;
    fpair_pkg::pair_kind_e        kind_w;

    assign gt_kind = kind_w;

    fault_store #(
        .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .BLK_BITS(BLK_BITS)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ld_en), .lock(busy),
        .wr_set(ld_set), .wr_way(ld_way), .wr_bad(ld_bad), .wr_mask(ld_mask),
        .rd_set(rd_set), .rd_masks(set_masks), .rd_bad(set_bad)
    );

    pair_finder #(
        .NUM_WAYS(NUM_WAYS), .BLK_BITS(BLK_BITS)
    ) u_find (
        .set_masks(set_masks), .set_bad(set_bad), .free_ways(free_ways),
        .cur_way(cur_way), .found(found), .match_way(match_way), .cur_mask(cur_mask)
    );

    pair_sequencer #(
        .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .BLK_BITS(BLK_BITS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .set_bad(set_bad), .found(found), .match_way(match_way), .cur_mask(cur_mask),
        .rd_set(rd_set), .cur_way(cur_way), .free_ways(free_ways),
        .busy(busy), .done(done),
        .gt_we(gt_we), .gt_set(gt_set), .gt_way(gt_way), .gt_kind(kind_w),
        .gt_partner(gt_partner),
        .sel_we(sel_we), .sel_set(sel_set), .sel_way(sel_way), .sel_mask(sel_mask)
    );

endmodule

// File: tb/sim_fault_pair_engine.sv
module sim_fault_pair_engine;

    localparam int S  = 4;
    localparam int W  = 4;
    localparam int BB = 16;
    localparam int SW = $clog2(S);
    localparam int WW = $clog2(W);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [SW-1:0] ld_set = '0;
    logic [WW-1:0] ld_way = '0;
    logic          ld_bad = 1'b0;
    logic [BB-1:0] ld_mask = '0;
    logic          start = 1'b0;
    logic          busy, done, gt_we, sel_we;
    logic [SW-1:0] gt_set, sel_set;
    logic [WW-1:0] gt_way, gt_partner, sel_way;
    logic [1:0]    gt_kind;
    logic [BB-1:0] sel_mask;

    int n_tests = 0;
    int n_fail  = 0;

    // model inputs, expected and observed tables
    logic [BB-1:0] m_mask [S][W];
    logic          m_bad  [S][W];
    logic [1:0]    e_kind [S][W];
    logic [WW-1:0] e_part [S][W];
    logic          e_selv [S][W];
    logic [BB-1:0] e_sel  [S][W];
    logic [1:0]    g_kind [S][W];
    logic [WW-1:0] g_part [S][W];
    int            g_seen [S][W];
    logic          g_selv [S][W];
    logic [BB-1:0] g_sel  [S][W];
    logic [31:0]   lfsr = 32'h1D2C_3B4A;

    always #2 clk = ~clk;

    fault_pair_engine #(.NUM_SETS(S), .NUM_WAYS(W), .BLK_BITS(BB)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_set(ld_set), .ld_way(ld_way),
        .ld_bad(ld_bad), .ld_mask(ld_mask), .start(start), .busy(busy), .done(done),
        .gt_we(gt_we), .gt_set(gt_set), .gt_way(gt_way), .gt_kind(gt_kind),
        .gt_partner(gt_partner), .sel_we(sel_we), .sel_set(sel_set), .sel_way(sel_way),
        .sel_mask(sel_mask)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    // one load pulse, called at a negedge
    task automatic load_blk(input int s, input int w, input logic bad, input logic [BB-1:0] mask);
        m_bad[s][w]  = bad;
        m_mask[s][w] = mask;
        ld_en = 1'b1; ld_set = SW'(s); ld_way = WW'(w); ld_bad = bad; ld_mask = mask;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic clear_all();
        for (int s = 0; s < S; s++)
            for (int w = 0; w < W; w++) load_blk(s, w, 1'b0, '0);
    endtask

    // expected tables from the pairing rules
    task automatic model();
        for (int s = 0; s < S; s++) begin
            bit            tk [W];
            logic [WW-1:0] pt [W];
            for (int w = 0; w < W; w++) begin tk[w] = 0; pt[w] = '0; end
            for (int w = 0; w < W; w++) begin
                e_selv[s][w] = 1'b0;
                e_sel[s][w]  = '0;
                e_part[s][w] = WW'(w);
                if (!m_bad[s][w]) e_kind[s][w] = 2'b00;
                else if (tk[w]) begin e_kind[s][w] = 2'b10; e_part[s][w] = pt[w]; end
                else begin
                    int pick = -1;
                    for (int j = w + 1; j < W; j++)
                        if (pick < 0 && m_bad[s][j] && !tk[j] && ((m_mask[s][w] & m_mask[s][j]) == '0))
                            pick = j;
                    if (pick >= 0) begin
                        e_kind[s][w] = 2'b01; e_part[s][w] = WW'(pick);
                        e_selv[s][w] = 1'b1;  e_sel[s][w] = m_mask[s][w];
                        tk[pick] = 1; pt[pick] = WW'(w);
                    end else e_kind[s][w] = 2'b11;
                end
            end
        end
    endtask

    // start a scan, collect all writes, check order and done timing
    task automatic run_scan(input bit disturb);
        int  cyc = 0;
        int  nwr = 0;
        bit  prev_we = 0;
        bit  seen_done = 0;
        for (int s = 0; s < S; s++)
            for (int w = 0; w < W; w++) begin g_seen[s][w] = 0; g_selv[s][w] = 0; end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!seen_done && cyc < 2000) begin
            cyc++;
            if (cyc == 1) chk(busy == 1'b1, "R10 busy after start", 32'(busy), 1);
            if (disturb) begin
                if (cyc == 3) begin ld_en = 1'b1; ld_set = SW'(S-1); ld_way = WW'(W-1); ld_bad = 1'b1; ld_mask = 16'h0002; end
                if (cyc == 4) ld_en = 1'b0;
                if (cyc == 5) start = 1'b1;
                if (cyc == 6) start = 1'b0;
            end
            if (gt_we) begin
                chk(32'(gt_set) == nwr / W && 32'(gt_way) == nwr % W, "R2 write order",
                    {16'(gt_set), 16'(gt_way)}, {16'(nwr / W), 16'(nwr % W)});
                g_kind[gt_set][gt_way] = gt_kind;
                g_part[gt_set][gt_way] = gt_partner;
                g_seen[gt_set][gt_way]++;
                nwr++;
            end
            if (sel_we) begin
                g_selv[sel_set][sel_way] = 1'b1;
                g_sel[sel_set][sel_way]  = sel_mask;
            end
            if (done) begin
                seen_done = 1;
                chk(prev_we && !gt_we && !busy, "R10 done timing", {prev_we, gt_we, busy}, 3'b100);
            end
            prev_we = gt_we;
            if (!seen_done) @(negedge clk);
        end
        chk(seen_done, "R10 done seen", 32'(seen_done), 1);
        chk(nwr == S * W, "R2 write count", nwr, S * W);
        @(negedge clk);
        chk(!done, "R10 done is a pulse", 32'(done), 0);
    endtask

    task automatic compare(input string req);
        for (int s = 0; s < S; s++)
            for (int w = 0; w < W; w++) begin
                chk(g_seen[s][w] == 1 && g_kind[s][w] == e_kind[s][w] && g_part[s][w] == e_part[s][w],
                    req, {8'(g_seen[s][w]), 8'(g_kind[s][w]), 16'(g_part[s][w])},
                    {8'd1, 8'(e_kind[s][w]), 16'(e_part[s][w])});
                chk(g_selv[s][w] == e_selv[s][w] && (!e_selv[s][w] || g_sel[s][w] == e_sel[s][w]),
                    {req, " R7 selector"}, {15'(g_selv[s][w]), g_sel[s][w]}, {15'(e_selv[s][w]), e_sel[s][w]});
            end
    endtask

    task automatic t_reset();
        chk(!busy && !done && !gt_we && !sel_we, "R10 reset state", {busy, done, gt_we, sel_we}, 0);
    endtask

    task automatic t_all_good();
        clear_all(); model(); run_scan(0);
        compare("R3 all good");
    endtask

    task automatic t_flag_clear();
        clear_all();
        load_blk(1, 2, 1'b0, 16'hFFFF);
        load_blk(1, 0, 1'b1, 16'h0001);
        load_blk(1, 1, 1'b1, 16'h0002);
        model(); run_scan(0);
        chk(g_kind[1][2] == 2'b00 && g_part[1][2] == 2, "R3 flag clear stays solo", g_kind[1][2], 0);
        chk(g_kind[1][0] == 2'b01 && g_part[1][0] == 1, "R1 loaded data used", g_part[1][0], 1);
        compare("R1 flag clear");
    endtask

    task automatic t_conflict();
        clear_all();
        load_blk(0, 0, 1'b1, 16'h0001);
        load_blk(0, 1, 1'b1, 16'h0001);
        load_blk(0, 2, 1'b1, 16'h0002);
        model(); run_scan(0);
        chk(g_kind[0][0] == 2'b01 && g_part[0][0] == 2, "R4 shared bad cell skipped", g_part[0][0], 2);
        chk(g_kind[0][1] == 2'b11, "R8 unmatched disabled", g_kind[0][1], 3);
        chk(g_kind[0][2] == 2'b10 && g_part[0][2] == 0, "R6 secondary points back", g_part[0][2], 0);
        chk(g_selv[0][0] && g_sel[0][0] == 16'h0001, "R7 selector mask", g_sel[0][0], 1);
        compare("R4 conflict");
    endtask

    task automatic t_greedy();
        clear_all();
        load_blk(2, 0, 1'b1, 16'h0001);
        load_blk(2, 1, 1'b1, 16'h0002);
        load_blk(2, 2, 1'b1, 16'h0004);
        load_blk(2, 3, 1'b1, 16'h0008);
        model(); run_scan(0);
        chk(g_part[2][0] == 1 && g_kind[2][0] == 2'b01, "R5 nearest partner", g_part[2][0], 1);
        chk(g_part[2][2] == 3 && g_kind[2][2] == 2'b01, "R5 claimed way skipped", g_part[2][2], 3);
        chk(g_kind[2][1] == 2'b10 && g_kind[2][3] == 2'b10, "R6 both secondaries",
            {g_kind[2][1], g_kind[2][3]}, 4'b1010);
        compare("R5 greedy");
    endtask

    task automatic t_set_bound();
        clear_all();
        load_blk(0, 3, 1'b1, 16'h0010);
        load_blk(1, 0, 1'b1, 16'h0020);
        for (int w = 0; w < W; w++) load_blk(3, w, 1'b1, 16'h8000);
        model(); run_scan(0);
        chk(g_kind[0][3] == 2'b11 && g_kind[1][0] == 2'b11, "R9 no cross-set pair",
            {g_kind[0][3], g_kind[1][0]}, 4'b1111);
        chk(g_kind[3][0] == 2'b11 && g_kind[3][3] == 2'b11, "R8 all overlapping disabled",
            {g_kind[3][0], g_kind[3][3]}, 4'b1111);
        compare("R9 set bound");
    endtask

    task automatic t_busy_ignore();
        clear_all();
        load_blk(3, 2, 1'b1, 16'h0001);
        model(); run_scan(1);
        chk(g_kind[3][2] == 2'b11 && g_kind[3][3] == 2'b00, "R1 load during scan ignored",
            {g_kind[3][2], g_kind[3][3]}, 4'b1100);
        compare("R2 start during scan ignored");
    endtask

    task automatic t_random(input int rounds);
        for (int r = 0; r < rounds; r++) begin
            for (int s = 0; s < S; s++)
                for (int w = 0; w < W; w++) begin
                    logic [BB-1:0] mk = BB'(rnd() & rnd() & rnd());
                    load_blk(s, w, (rnd() % 4) != 0, mk);
                end
            model(); run_scan(0);
            compare("R5 mixed pattern");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_good();
        t_flag_clear();
        t_conflict();
        t_greedy();
        t_set_bound();
        t_busy_ignore();
        t_random(6);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule